// File: doc/BRIEF.md
# Serial Configuration Register Bank for an Imaging Front End

This block is a write-only, three-wire serial slave that holds the settings of a camera sensor's analog front end. A host pulls an active-low select down, clocks twelve bits on the serial clock, and raises select again. The first two bits choose the target register. The remaining ten bits carry its value, most significant bit first. The four targets are a 10-bit converter clamp code, a 4-bit filter cut-off code, a 10-bit amplifier gain code and a 3-bit pulse-polarity word. Their current values are driven on parallel outputs.

All three serial inputs pass through a synchronizer into the system clock domain. Serial clock edges are found there, so the system clock must run at least four times faster than the serial clock. A frame takes effect only when select rises after exactly twelve bits. The block then raises a one-cycle write strobe and shows the address that was written. A frame of any other length leaves every register unchanged and raises a one-cycle error pulse instead.

Changing the clamp code requires that the gain be rewritten afterwards. A sticky flag reports this until the next gain write.

Top module: `afe_cfg_serial_bank`

## Requirements
- R1: After a synchronous reset, the outputs take these values: clamp code 0, cut-off code 0, gain code 0, polarity word 3'b110, refresh flag 0, write strobe 0 and frame error 0.
- R2: Bits are captured on rising serial clock edges, and only while select is low. Serial clock activity while select is high has no effect. A frame is sent as address bit 1, address bit 0, then data bit 9 down to data bit 0.
- R3: Address 2'b00 loads all ten data bits into the clamp code.
- R4: Address 2'b01 loads data bits 3..0 into the cut-off code. Data bits 9..4 are ignored.
- R5: Address 2'b10 loads all ten data bits into the gain code.
- R6: Address 2'b11 loads data bits 2..0 into the polarity word, and the upper bits are ignored. The bits mean: bit 0 = 1 makes the sample pulses active low; bit 1 = 1 makes the clamp pulses active high; bit 2 = 1 makes the converter clock act on its rising edge.
- R7: The refresh flag sets on every clamp write and clears on the next gain write. Cut-off writes, polarity writes and rejected frames leave it unchanged.
- R8: When select rises after exactly twelve bits, the addressed register updates. In the same cycle the write strobe goes high for one cycle and the address output shows the 2-bit address. No register changes in a cycle without the strobe.
- R9: When select rises after fewer or more than twelve bits, no register changes and no strobe occurs. Instead, the frame error output goes high for one cycle.
- R10: Frames are captured correctly with a serial clock as fast as one quarter of the system clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sel_n_i | input | 1 | Serial select, active low (asynchronous) |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| sdata_i | input | 1 | Serial data (asynchronous) |
| clamp_code_o | output | 10 | Converter clamp code |
| cutoff_code_o | output | 4 | Filter cut-off code |
| gain_code_o | output | 10 | Amplifier gain code |
| edge_ctrl_o | output | 3 | Pulse polarity word |
| gain_refresh_o | output | 1 | Gain must be rewritten after a clamp change |
| wr_stb_o | output | 1 | One-cycle pulse when a register is written |
| wr_addr_o | output | 2 | Address of the register just written |
| frame_err_o | output | 1 | One-cycle pulse for a frame of the wrong length |

## Verification
A bad bit counter or shift register shows up at the ports within one frame. Either a valid frame raises the error pulse, or a register takes a value that is shifted or partly replaced. A wrong address decode shows at the strobe as the wrong register changing. A stuck refresh flag is visible at the first strobe for a clamp or gain write. Each strobe or error pulse is compared with the expected register image in that same cycle, so a fault is reported on the event that caused it.

// File: rtl/afe_cfg_pkg.sv
`timescale 1ns/1ps
package afe_cfg_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 10;
  localparam int CUT_W  = 4;
  localparam int POL_W  = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CLAMP  = 2'b00,
    ADR_CUTOFF = 2'b01,
    ADR_GAIN   = 2'b10,
    ADR_POL    = 2'b11
  } cfg_addr_e;

  // bit0 sample active-low, bit1 clamp active-high, bit2 rising-edge clock
  localparam logic [POL_W-1:0] POL_DEFAULT = 3'b110;
endpackage

// File: rtl/cfg_sync_chain.sv
`timescale 1ns/1ps
module cfg_sync_chain #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] chain_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= RST_VAL;
        else     chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) chain_q[s] <= RST_VAL;
        else     chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/cfg_frame_shifter.sv
`timescale 1ns/1ps
module cfg_frame_shifter
  import afe_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_s,
  input  logic              sclk_s,
  input  logic              sdata_s,
  output logic              commit_o,
  output logic              err_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int FRAME_LEN = ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_LEN + 1);

  logic [FRAME_LEN-1:0] shreg_q;
  logic [CNT_W-1:0]     cnt_q;
  logic                 sclk_prev_q, sel_prev_q;
  logic                 sclk_rise, sel_rise;

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sel_rise  = sel_n_s & ~sel_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q     <= '0;
      cnt_q       <= '0;
      sclk_prev_q <= 1'b0;
      sel_prev_q  <= 1'b1;
      commit_o    <= 1'b0;
      err_o       <= 1'b0;
      addr_o      <= '0;
      data_o      <= '0;
    end else begin
      sclk_prev_q <= sclk_s;
      sel_prev_q  <= sel_n_s;
      commit_o    <= 1'b0;
      err_o       <= 1'b0;
      if (sel_rise) begin
        if (cnt_q == CNT_FULL) begin
          commit_o <= 1'b1;
          addr_o   <= shreg_q[FRAME_LEN-1 -: ADDR_W];
          data_o   <= shreg_q[DATA_W-1:0];
        end else begin
          err_o <= 1'b1;
        end
      end
      if (sel_n_s) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shreg_q <= {shreg_q[FRAME_LEN-2:0], sdata_s};
        if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assert_commit_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(commit_o && err_o));
  assert_commit_single_R8: assert property (@(posedge clk) disable iff (rst)
    commit_o |=> !commit_o);
  assert_err_single_R9: assert property (@(posedge clk) disable iff (rst)
    err_o |=> !err_o);
endmodule

// File: rtl/cfg_reg_file.sv
`timescale 1ns/1ps
module cfg_reg_file
  import afe_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] clamp_o,
  output logic [CUT_W-1:0]  cutoff_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [POL_W-1:0]  pol_o,
  output logic              refresh_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      clamp_o   <= '0;
      cutoff_o  <= '0;
      gain_o    <= '0;
      pol_o     <= POL_DEFAULT;
      refresh_o <= 1'b0;
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      wr_stb_o <= commit_i;
      if (commit_i) begin
        wr_addr_o <= addr_i;
        unique case (cfg_addr_e'(addr_i))
          ADR_CLAMP: begin
            clamp_o   <= data_i;
            refresh_o <= 1'b1;
          end
          ADR_CUTOFF: cutoff_o <= data_i[CUT_W-1:0];
          ADR_GAIN: begin
            gain_o    <= data_i;
            refresh_o <= 1'b0;
          end
          ADR_POL: pol_o <= data_i[POL_W-1:0];
        endcase
      end
    end
  end

  assert_regs_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_stb_o |-> ($stable(clamp_o) && $stable(cutoff_o) && $stable(gain_o)
                   && $stable(pol_o) && $stable(refresh_o)));
  assert_refresh_set_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb_o && wr_addr_o == ADR_CLAMP) |-> refresh_o);
  assert_refresh_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_stb_o && wr_addr_o == ADR_GAIN) |-> !refresh_o);
  assert_single_target_R8: assert property (@(posedge clk) disable iff (rst)
    wr_stb_o |-> $countones({!$stable(clamp_o), !$stable(cutoff_o),
                             !$stable(gain_o), !$stable(pol_o)}) <= 1);
endmodule

// File: rtl/afe_cfg_serial_bank.sv
`timescale 1ns/1ps
module afe_cfg_serial_bank
  import afe_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  output logic [DATA_W-1:0] clamp_code_o,
  output logic [CUT_W-1:0]  cutoff_code_o,
  output logic [DATA_W-1:0] gain_code_o,
  output logic [POL_W-1:0]  edge_ctrl_o,
  output logic              gain_refresh_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic              frame_err_o
);
  logic [2:0]        pins_s;
  logic              commit;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;

  cfg_sync_chain #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i ({sel_n_i, sclk_i, sdata_i}),
    .sync_o  (pins_s)
  );

  cfg_frame_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .sel_n_s  (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .sdata_s  (pins_s[0]),
    .commit_o (commit),
    .err_o    (frame_err_o),
    .addr_o   (f_addr),
    .data_o   (f_data)
  );

  cfg_reg_file u_regs (
    .clk       (clk),
    .rst       (rst),
    .commit_i  (commit),
    .addr_i    (f_addr),
    .data_i    (f_data),
    .clamp_o   (clamp_code_o),
    .cutoff_o  (cutoff_code_o),
    .gain_o    (gain_code_o),
    .pol_o     (edge_ctrl_o),
    .refresh_o (gain_refresh_o),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o)
  );

  assert_stb_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(wr_stb_o && frame_err_o));
  assert_err_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    frame_err_o |-> ($stable(clamp_code_o) && $stable(gain_code_o)
                     && $stable(cutoff_code_o) && $stable(edge_ctrl_o)));
endmodule

// File: tb/tb_afe_cfg_serial_bank.sv
`timescale 1ns/1ps
module tb_afe_cfg_serial_bank;
  import afe_cfg_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1, sclk = 1'b0, sdata = 1'b0;
  logic [9:0] clamp, gain;
  logic [3:0] cut;
  logic [2:0] pol;
  logic       refresh, stb, ferr;
  logic [1:0] waddr;

  always #2.5 clk = ~clk;

  afe_cfg_serial_bank dut (
    .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .sdata_i(sdata),
    .clamp_code_o(clamp), .cutoff_code_o(cut), .gain_code_o(gain),
    .edge_ctrl_o(pol), .gain_refresh_o(refresh), .wr_stb_o(stb),
    .wr_addr_o(waddr), .frame_err_o(ferr)
  );

  typedef struct packed {
    logic       err;
    logic [1:0] addr;
    logic [9:0] clamp;
    logic [3:0] cut;
    logic [9:0] gain;
    logic [2:0] pol;
    logic       flag;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_vec = 0, n_bad = 0;
  bit    done = 0;

  logic [9:0] m_clamp = '0, m_gain = '0;
  logic [3:0] m_cut = '0;
  logic [2:0] m_pol = 3'b110;
  logic       m_flag = 1'b0;

  task automatic check(bit ok, string tag, exp_t act, exp_t exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_bits(int nbits, logic [15:0] bits, int half);
    sel_n = 1'b0;
    tick(half);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = bits[i];
      sclk  = 1'b0;
      tick(half);
      sclk  = 1'b1;
      tick(half);
    end
    sclk = 1'b0;
    tick(half);
    sel_n = 1'b1;
    tick(2 * half + 8);
  endtask

  function automatic exp_t model_image(bit err, logic [1:0] a);
    return '{err: err, addr: a, clamp: m_clamp, cut: m_cut, gain: m_gain,
             pol: m_pol, flag: m_flag};
  endfunction

  task automatic write_reg(logic [1:0] a, logic [9:0] d, int half, string tag);
    case (a)
      2'b00: begin m_clamp = d; m_flag = 1'b1; end
      2'b01: m_cut = d[3:0];
      2'b10: begin m_gain = d; m_flag = 1'b0; end
      default: m_pol = d[2:0];
    endcase
    expq.push_back(model_image(1'b0, a));
    tagq.push_back(tag);
    send_bits(12, {4'b0, a, d}, half);
  endtask

  task automatic bad_frame(int nbits, logic [15:0] bits, string tag);
    expq.push_back(model_image(1'b1, 2'b00));
    tagq.push_back(tag);
    send_bits(nbits, bits, 4);
  endtask

  // monitor: pops an expected image on every strobe or error pulse
  always @(negedge clk) begin
    if (!rst && (stb || ferr)) begin
      exp_t act, exp;
      string tag;
      act = '{err: ferr, addr: (ferr ? 2'b00 : waddr), clamp: clamp, cut: cut,
              gain: gain, pol: pol, flag: refresh};
      if (expq.size() == 0) begin
        check(1'b0, "R8 unexpected event", act, '0);
      end else begin
        exp = expq.pop_front();
        tag = tagq.pop_front();
        check(act == exp && !(stb && ferr), tag, act, exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tick(5);
    rst = 1'b0;
    tick(3);
    @(negedge clk);
    check(clamp == 0 && cut == 0 && gain == 0 && pol == 3'b110 && !refresh
          && !stb && !ferr, "R1 reset defaults",
          '{err: ferr, addr: 2'b00, clamp: clamp, cut: cut, gain: gain, pol: pol, flag: refresh},
          model_image(1'b0, 2'b00));
    tick(1);

    write_reg(2'b00, 10'h2A5, 4, "R3 clamp write, R7 flag set");
    write_reg(2'b01, 10'h3F9, 4, "R4 cut-off low bits only");
    write_reg(2'b11, 10'h005, 4, "R6 polarity write");
    write_reg(2'b10, 10'h155, 4, "R5 gain write, R7 flag clear");

    // serial clock toggles with select high must not shift anything
    for (int i = 0; i < 6; i++) begin
      sdata = i[0]; sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
    end
    write_reg(2'b00, 10'h3FF, 4, "R2 idle clocks ignored");

    bad_frame(11, 16'h0155, "R9 short frame");
    bad_frame(13, 16'h1ABC, "R9 long frame");
    write_reg(2'b11, 10'h3F8, 4, "R6 polarity upper bits ignored");
    write_reg(2'b10, 10'h2C3, 2, "R10 gain at quarter rate");
    write_reg(2'b00, 10'h000, 2, "R10 clamp at quarter rate");
    write_reg(2'b01, 10'h006, 4, "R7 flag held across cut-off write");
    write_reg(2'b10, 10'h001, 4, "R5 gain write clears flag");

    tick(30);
    check(expq.size() == 0, "R8 all expected writes observed",
          '{err: 1'b0, addr: 2'b00, clamp: 10'(expq.size()), cut: 4'h0,
            gain: 10'h0, pol: 3'h0, flag: 1'b0}, '0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule